// File: doc/BRIEF.md
# Windowed Signature Checker with Conditional Commit

This block sits between a circuit under debug and an on-chip trace buffer. It folds each valid 32-bit debug word into a multiple-input signature register (MISR). After every eighth valid word it compares the finished signature with a golden value fetched from the trace buffer, and emits one tag bit per window toward an external debugger. The tag is 1 when the two differ. The register is then cleared for the next window.

Lower-level signatures, produced elsewhere, arrive on their own input during a window and are held in a small capture buffer. When a window's tag is 1, the held signatures are written into the trace buffer one per cycle. When the tag is 0 they are dropped. Stores go into locations whose golden values have already been consumed. The block stops storing and raises a sticky overflow flag if a window's stores would reach a golden entry that has not been compared yet.

Top module: `misr_golden_gate`

## Requirements
- R1: On each cycle with `dbg_valid`=1 the signature becomes `{s[30:0],0} ^ (s[31] ? 32'h00400007 : 0) ^ dbg_word`. The signature starts each window at zero.
- R2: A window closes on its eighth valid word. In the following cycle `tag_valid` is 1 for exactly one cycle. `tag_bit` is 1 if the closing signature differs from `gold_data` as presented during the closing cycle, and 0 if it matches.
- R3: `gold_addr` equals the number of windows closed so far, starting at 0, so window k is compared with the golden entry at address k.
- R4: Cycles with `dbg_valid`=0 have no effect on the signature or on the count of words in the window, whatever `dbg_word` holds.
- R5: Up to 2 low-level signatures per window are captured in arrival order. Further ones in the same window are ignored. A signature that arrives in the closing cycle belongs to the closing window.
- R6: When a window's tag is 1, its captured signatures are written with `tb_we`=1 in arrival order, one per cycle, beginning the cycle after the tag edge. They go to consecutive addresses from a write pointer that starts at 0. A window with none captured writes nothing.
- R7: When a window's tag is 0, its captured signatures are discarded: no write takes place and the write pointer keeps its value.
- R8: When a mismatching window's stores would extend past the number of windows compared (including that window), `overflow` becomes 1 and stays 1. That window and all later ones store nothing, and tags continue.
- R9: Right after reset, `tag_valid`, `tb_we` and `overflow` are 0 and `gold_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_valid | input | 1 | Debug word qualifier |
| dbg_word | input | 32 | Debug word from the circuit under debug |
| ll_valid | input | 1 | Low-level signature strobe |
| ll_sig | input | 32 | Low-level signature value |
| gold_addr | output | 6 | Trace buffer address of the golden signature for the open window |
| gold_data | input | 32 | Golden signature read at `gold_addr` |
| tb_we | output | 1 | Trace buffer write enable |
| tb_addr | output | 6 | Trace buffer write address |
| tb_wdata | output | 32 | Trace buffer write data |
| tag_valid | output | 1 | Tag bit strobe, one per window |
| tag_bit | output | 1 | 1 = signature mismatch |
| overflow | output | 1 | Sticky store overflow |

## Verification
The tag, the new golden address and the overflow flag all change one edge after the cycle that carries the eighth valid word. Committed writes appear on the following cycles, one per edge. The bench drives each cycle's inputs on the falling edge and advances a behavioural model by exactly one clock. It then compares every output on the next falling edge, so each result is checked in the cycle it is due and in no other. The stimulus mixes matching and mismatching windows, idle cycles with junk data, excess low-level signatures and a signature that arrives in the closing cycle, and it drives the pointer into overflow.

// File: rtl/misr_golden_gate.sv
module misr_golden_gate #(
  parameter int W = 32,
  parameter int SPS = 8,
  parameter int NSLOT = 2,
  parameter int DEPTH = 64,
  parameter logic [W-1:0] POLY = 32'h0040_0007
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dbg_valid,
  input  logic [W-1:0] dbg_word,
  input  logic ll_valid,
  input  logic [W-1:0] ll_sig,
  output logic [$clog2(DEPTH)-1:0] gold_addr,
  input  logic [W-1:0] gold_data,
  output logic tb_we,
  output logic [$clog2(DEPTH)-1:0] tb_addr,
  output logic [W-1:0] tb_wdata,
  output logic tag_valid,
  output logic tag_bit,
  output logic overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int CW = (SPS > 1) ? $clog2(SPS) : 1;
  localparam int SW = $clog2(NSLOT + 1);
  localparam int IW = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic [W-1:0] acc, acc_nxt;
  logic [CW-1:0] wcnt;
  logic [PW-1:0] done, done_n, wp, dbase;
  logic [W-1:0] cap [NSLOT];
  logic [W-1:0] cap_n [NSLOT];
  logic [W-1:0] dbuf [NSLOT];
  logic [SW-1:0] ccnt, cnt_end, dcnt, didx;
  logic last, mism, take, fits, commit, ovf_set;
  logic [PW-1:0] addr_full;

  assign acc_nxt = {acc[W-2:0], 1'b0} ^ (acc[W-1] ? POLY : '0) ^ dbg_word;
  assign last    = dbg_valid && (wcnt == CW'(SPS - 1));
  assign mism    = acc_nxt != gold_data;
  assign done_n  = (done == PW'(DEPTH)) ? done : done + 1'b1;
  assign take    = ll_valid && (ccnt < SW'(NSLOT));
  assign cnt_end = ccnt + SW'(take);
  assign fits    = ({1'b0, wp} + (PW+1)'(cnt_end)) <= {1'b0, done_n};
  assign commit  = last && mism && !overflow && fits;
  assign ovf_set = last && mism && !overflow && !fits;

  for (genvar i = 0; i < NSLOT; i++) begin : g_capn
    assign cap_n[i] = (take && ccnt == SW'(i)) ? ll_sig : cap[i];
  end

  assign gold_addr = done[AW-1:0];
  assign tb_we     = didx < dcnt;
  assign addr_full = dbase + PW'(didx);
  assign tb_addr   = addr_full[AW-1:0];
  assign tb_wdata  = tb_we ? dbuf[didx[IW-1:0]] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
      wcnt <= '0;
      done <= '0;
      wp <= '0;
      dbase <= '0;
      ccnt <= '0;
      dcnt <= '0;
      didx <= '0;
      tag_valid <= 1'b0;
      tag_bit <= 1'b0;
      overflow <= 1'b0;
      for (int i = 0; i < NSLOT; i++) begin
        cap[i] <= '0;
        dbuf[i] <= '0;
      end
    end else begin
      tag_valid <= last;
      if (last) tag_bit <= mism;
      if (ovf_set) overflow <= 1'b1;

      if (dbg_valid) begin
        if (last) begin
          acc <= '0;
          wcnt <= '0;
          done <= done_n;
        end else begin
          acc <= acc_nxt;
          wcnt <= wcnt + 1'b1;
        end
      end

      if (last) begin
        ccnt <= '0;
      end else if (take) begin
        cap[ccnt[IW-1:0]] <= ll_sig;
        ccnt <= ccnt + 1'b1;
      end

      if (last) begin
        for (int i = 0; i < NSLOT; i++) dbuf[i] <= cap_n[i];
        dcnt <= commit ? cnt_end : '0;
        didx <= '0;
        dbase <= wp;
        if (commit) wp <= wp + PW'(cnt_end);
      end else if (tb_we) begin
        didx <= didx + 1'b1;
      end
    end
  end

  p_tag_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tag_valid |=> !tag_valid);
  p_tag_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tag_valid |-> $past(dbg_valid));
  p_gold_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_valid && $past(done) != PW'(DEPTH)) |-> gold_addr == AW'($past(gold_addr) + 1'b1));
  p_drain_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (last && tb_we) |-> (didx + 1'b1 == dcnt));
  p_match_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_valid && !tag_bit) |-> !tb_we);
  p_write_compared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tb_we |-> ({1'b0, tb_addr} < done));
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  p_no_store_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && $past(overflow)) |-> !tb_we);
endmodule

// File: tb/tb_misr_golden_gate.sv
module tb_misr_golden_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dbg_valid = 1'b0, ll_valid = 1'b0;
  logic [31:0] dbg_word = '0, ll_sig = '0, gold_data;
  logic [5:0] gold_addr, tb_addr;
  logic [31:0] tb_wdata;
  logic tb_we, tag_valid, tag_bit, overflow;

  always #2 clk = ~clk;

  bit [31:0] gmem [64];
  assign gold_data = gmem[gold_addr];

  misr_golden_gate dut (
    .clk(clk), .rst_n(rst_n), .dbg_valid(dbg_valid), .dbg_word(dbg_word),
    .ll_valid(ll_valid), .ll_sig(ll_sig), .gold_addr(gold_addr), .gold_data(gold_data),
    .tb_we(tb_we), .tb_addr(tb_addr), .tb_wdata(tb_wdata),
    .tag_valid(tag_valid), .tag_bit(tag_bit), .overflow(overflow));

  int checks = 0, errors = 0;
  string ph = "R9";

  bit [31:0] m_acc = 0;
  int m_cnt = 0, m_k = 0, m_wp = 0;
  bit m_ovf = 0, m_tv = 0, m_tb = 0;
  bit [31:0] capq [$];
  int wq_a [$];
  bit [31:0] wq_d [$];
  bit [31:0] seed = 32'h1234_5678;
  bit [31:0] words [10][8];
  bit mm [10] = '{0, 0, 1, 1, 1, 1, 1, 1, 1, 0};
  int nll [10] = '{2, 2, 2, 0, 1, 3, 2, 2, 2, 1};

  function automatic bit [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  function automatic bit [31:0] fold(bit [31:0] a, bit [31:0] d);
    return {a[30:0], 1'b0} ^ (a[31] ? 32'h0040_0007 : 32'h0) ^ d;
  endfunction

  task automatic chk(bit ok, string req, bit [31:0] act, bit [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s phase %s actual %h expected %h", req, ph, act, exp);
    end
  endtask

  task automatic step(bit v, bit [31:0] w, bit lv, bit [31:0] l);
    int done;
    dbg_valid = v; dbg_word = w; ll_valid = lv; ll_sig = l;
    if (wq_a.size() > 0) begin void'(wq_a.pop_front()); void'(wq_d.pop_front()); end
    m_tv = 0;
    if (lv && capq.size() < 2) capq.push_back(l);
    if (v) begin m_acc = fold(m_acc, w); m_cnt++; end
    if (v && m_cnt == 8) begin
      m_tv = 1;
      m_tb = (m_acc != gmem[m_k]);
      m_k++;
      done = (m_k > 64) ? 64 : m_k;
      if (m_tb && !m_ovf) begin
        if (m_wp + capq.size() <= done) begin
          foreach (capq[i]) begin wq_a.push_back(m_wp + i); wq_d.push_back(capq[i]); end
          m_wp += capq.size();
        end else m_ovf = 1;
      end
      capq.delete();
      m_acc = 0; m_cnt = 0;
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag_valid == m_tv, "R2 tag_valid", 32'(tag_valid), 32'(m_tv));
    if (m_tv) chk(tag_bit == m_tb, "R1/R2 tag_bit", 32'(tag_bit), 32'(m_tb));
    chk(gold_addr == 6'(m_k), "R3 gold_addr", 32'(gold_addr), 32'(m_k % 64));
    chk(tb_we == (wq_a.size() > 0), "R6/R7 tb_we", 32'(tb_we), 32'(wq_a.size() > 0));
    if (wq_a.size() > 0 && tb_we) begin
      chk(tb_addr == 6'(wq_a[0]), "R6 tb_addr", 32'(tb_addr), 32'(wq_a[0]));
      chk(tb_wdata == wq_d[0], "R5/R6 tb_wdata", tb_wdata, wq_d[0]);
    end
    chk(overflow == m_ovf, "R8 overflow", 32'(overflow), 32'(m_ovf));
  endtask

  task automatic run_window(int w, bit gaps);
    for (int i = 0; i < 8; i++) begin
      if (gaps) step(1'b0, rnd(), 1'b0, 32'h0);
      step(1'b1, words[w][i], (i >= 8 - nll[w]), rnd());
    end
    for (int i = 0; i < 3; i++) step(1'b0, rnd(), 1'b0, 32'h0);
  endtask

  initial begin
    for (int w = 0; w < 10; w++) begin
      bit [31:0] s = 0;
      for (int i = 0; i < 8; i++) begin words[w][i] = rnd(); s = fold(s, words[w][i]); end
      gmem[w] = mm[w] ? (s ^ 32'h1) : s;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    ph = "R9";
    chk(tag_valid == 0, "R9 tag_valid", 32'(tag_valid), 0);
    chk(tb_we == 0, "R9 tb_we", 32'(tb_we), 0);
    chk(overflow == 0, "R9 overflow", 32'(overflow), 0);
    chk(gold_addr == 0, "R9 gold_addr", 32'(gold_addr), 0);
    ph = "R7";  run_window(0, 0); run_window(1, 0);
    ph = "R6";  run_window(2, 0); run_window(3, 0); run_window(4, 0);
    ph = "R4";  run_window(5, 1); run_window(6, 1);
    ph = "R8";  run_window(7, 0); run_window(8, 0); run_window(9, 0);
    ph = "R5";  run_window(2, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule